// File: doc/BRIEF.md
# Clock-Pair Skew Error Detector

This block watches two clock-like signals that are meant to move in lockstep: a counter clock and a companion check clock. Both are asynchronous to the block. They are synchronised into a fast sampling clock domain, and their edges are found there. Two directional pairing rules are then enforced, each against its own programmable window measured in sampling-clock cycles:

- Every rising edge of the counter clock must be answered by a falling edge of the check clock.
- Every falling edge of the check clock must be answered by a rising edge of the counter clock.

When a window runs out before its answer arrives, one error is recorded. The block emits a one-cycle error pulse and advances an error tally that saturates at its maximum.

Detection can be paused with an enable input. It also stands down by itself when the check clock stops toggling. A system can therefore leave the check clock parked high or low, and no errors build up.

Top module: `skew_err_mon`

## Requirements
- R1: While reset is held, and right after it is released, `err_count` is 0 and `err_pulse` is 0.
- R2: A rising counter-clock edge opens window A for `win_a` sampling cycles. A check-clock falling edge seen in the same cycle, or 1 to `win_a` cycles later, closes it without error. If no such edge arrives in time, exactly one error is recorded.
- R3: A falling check-clock edge opens window B for `win_b` cycles. A counter-clock rising edge seen in the same cycle, or 1 to `win_b` cycles later, closes it without error. If no such edge arrives in time, exactly one error is recorded.
- R4: The two window lengths act independently. A length of 0 disables the rule that uses it, so that rule never records an error.
- R5: A new trigger edge that arrives while its window is still open restarts that window from its full length. An abandoned window never records an error of its own.
- R6: If the check clock has shown no edge for `IDLE_CYC` sampling cycles, including the stretch after reset, both windows are held closed and no error is recorded.
- R7: While `en` is 0, both windows are held closed and no error is recorded.
- R8: `err_count` increases by the number of errors found in a cycle, stops at 2^`CNT_W`-1, never wraps, and is cleared only by reset.
- R9: `err_pulse` is high for one cycle for each cycle in which at least one error is found. It is high in the same cycle that `err_count` first shows the increment, whether or not the count has saturated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Detection enable |
| cnt_clk_in | input | 1 | Monitored counter clock (asynchronous) |
| chk_clk_in | input | 1 | Monitored check clock (asynchronous) |
| win_a | input | WIN_W | Window A length in sampling cycles (0 disables rule A) |
| win_b | input | WIN_W | Window B length in sampling cycles (0 disables rule B) |
| err_count | output | CNT_W | Saturating error tally |
| err_pulse | output | 1 | One-cycle pulse per cycle with a new error |

## Verification
The bench builds the block with `CNT_W` = 4, `IDLE_CYC` = 32 and the default 3-bit windows and two-stage synchronisers. A 4-bit tally saturates at 15, so the sweeps reach saturation after a few dozen trials.

For each window length from 1 to 5, in each direction, the bench sweeps the answer delay from simultaneous to two cycles past the window. This covers both sides of every window boundary. The short 32-cycle idle limit makes the parked-check-clock case quick to reach.

// File: rtl/skew_pkg.sv
package skew_pkg;
   typedef struct packed {
      logic rise;
      logic fall;
   } edge_t;

   localparam int MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/sync_edge.sv
module sync_edge
   import skew_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  din,
   output edge_t edges
);
   if (STAGES < MIN_SYNC_STAGES) begin : g_bad_stages
      $error("sync_edge: STAGES must be at least %0d", MIN_SYNC_STAGES);
   end

   logic [STAGES-1:0] chain;
   logic              last;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last <= 1'b0;
      else        last <= chain[STAGES-1];
   end

   always_comb begin
      edges.rise = chain[STAGES-1] & ~last;
      edges.fall = ~chain[STAGES-1] & last;
   end
endmodule

// File: rtl/activity_watch.sv
module activity_watch #(
   parameter int IDLE_CYC = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   output logic idle
);
   if (IDLE_CYC < 1) begin : g_bad_idle
      $error("activity_watch: IDLE_CYC must be positive");
   end

   localparam int IW = $clog2(IDLE_CYC + 1);
   localparam logic [IW-1:0] LIMIT = IW'(IDLE_CYC);

   logic [IW-1:0] quiet;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              quiet <= LIMIT;
      else if (evt)            quiet <= '0;
      else if (quiet != LIMIT) quiet <= quiet + 1'b1;
   end

   assign idle = (quiet == LIMIT);
endmodule

// File: rtl/skew_window.sv
module skew_window #(
   parameter int WIN_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             trig,
   input  logic             partner,
   input  logic [WIN_W-1:0] len,
   output logic             expire
);
   if (WIN_W < 1) begin : g_bad_w
      $error("skew_window: WIN_W must be positive");
   end

   logic [WIN_W-1:0] remain;
   logic             open;

   assign open = (remain != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       remain <= '0;
      else if (clr)     remain <= '0;
      else if (trig)    remain <= partner ? '0 : len;
      else if (open)    remain <= partner ? '0 : remain - 1'b1;
   end

   assign expire = !clr && !trig && !partner && (remain == WIN_W'(1));
endmodule

// File: rtl/err_tally.sv
module err_tally #(
   parameter int CNT_W = 8,
   parameter int HITS  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [HITS-1:0]  hit,
   output logic [CNT_W-1:0] count,
   output logic             pulse
);
   if (CNT_W < 1) begin : g_bad_cnt
      $error("err_tally: CNT_W must be positive");
   end

   localparam int SW = CNT_W + $clog2(HITS + 1);
   localparam logic [SW-1:0] CAP = SW'((2 ** CNT_W) - 1);

   logic [SW-1:0] add;
   logic [SW-1:0] sum;

   always_comb begin
      add = '0;
      for (int i = 0; i < HITS; i++) add = add + SW'(hit[i]);
      sum = SW'(count) + add;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
         pulse <= 1'b0;
      end else begin
         count <= (sum > CAP) ? CAP[CNT_W-1:0] : sum[CNT_W-1:0];
         pulse <= |hit;
      end
   end
endmodule

// File: rtl/skew_err_mon.sv
module skew_err_mon
   import skew_pkg::*;
#(
   parameter int WIN_W    = 3,
   parameter int CNT_W    = 8,
   parameter int SYNC_N   = 2,
   parameter int IDLE_CYC = 256
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             cnt_clk_in,
   input  logic             chk_clk_in,
   input  logic [WIN_W-1:0] win_a,
   input  logic [WIN_W-1:0] win_b,
   output logic [CNT_W-1:0] err_count,
   output logic             err_pulse
);
   localparam int RULES = 2;

   edge_t            cnt_e;
   edge_t            chk_e;
   logic             chk_idle;
   logic             hold;
   logic [RULES-1:0] exp_v;

   sync_edge #(.STAGES(SYNC_N)) u_sync_cnt (
      .clk(clk), .rst_n(rst_n), .din(cnt_clk_in), .edges(cnt_e));

   sync_edge #(.STAGES(SYNC_N)) u_sync_chk (
      .clk(clk), .rst_n(rst_n), .din(chk_clk_in), .edges(chk_e));

   activity_watch #(.IDLE_CYC(IDLE_CYC)) u_act (
      .clk(clk), .rst_n(rst_n), .evt(chk_e.rise | chk_e.fall), .idle(chk_idle));

   assign hold = !en || chk_idle;

   // Rule A: counter rise answered by check fall.
   skew_window #(.WIN_W(WIN_W)) u_win_a (
      .clk(clk), .rst_n(rst_n), .clr(hold),
      .trig(cnt_e.rise), .partner(chk_e.fall), .len(win_a), .expire(exp_v[0]));

   // Rule B: check fall answered by counter rise.
   skew_window #(.WIN_W(WIN_W)) u_win_b (
      .clk(clk), .rst_n(rst_n), .clr(hold),
      .trig(chk_e.fall), .partner(cnt_e.rise), .len(win_b), .expire(exp_v[1]));

   err_tally #(.CNT_W(CNT_W), .HITS(RULES)) u_tally (
      .clk(clk), .rst_n(rst_n), .hit(exp_v), .count(err_count), .pulse(err_pulse));
endmodule

// File: rtl/skew_err_chk.sv
module skew_err_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic [CNT_W-1:0] err_count,
   input logic             err_pulse
);
   localparam logic [CNT_W-1:0] TOP = '1;

   always @(negedge clk) begin
      if (!rst_n) begin
         assert_reset_clear_R1: assert (err_count == '0 && !err_pulse);
      end
   end

   assert_change_needs_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (err_count != $past(err_count)) |-> err_pulse);

   assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err_count >= $past(err_count));

   assert_sat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(err_count) == TOP) |-> (err_count == TOP));

   assert_quiet_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(en) |-> !err_pulse);
endmodule

bind skew_err_mon skew_err_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .err_count(err_count), .err_pulse(err_pulse));

// File: tb/sim_skew_err_mon.sv
`timescale 1ns/1ps
module sim_skew_err_mon;
   localparam int WW   = 3;
   localparam int CW   = 4;
   localparam int IDLE = 32;
   localparam int MAXC = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en = 1'b0;
   logic          cnt_clk_in = 1'b0;
   logic          chk_clk_in = 1'b0;
   logic [WW-1:0] win_a = '0;
   logic [WW-1:0] win_b = '0;
   logic [CW-1:0] err_count;
   logic          err_pulse;

   int vectors = 0;
   int fails = 0;
   int exp_cnt = 0;
   int exp_events = 0;
   int pulses = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   skew_err_mon #(.WIN_W(WW), .CNT_W(CW), .SYNC_N(2), .IDLE_CYC(IDLE)) u0 (
      .clk(clk), .rst_n(rst_n), .en(en), .cnt_clk_in(cnt_clk_in), .chk_clk_in(chk_clk_in),
      .win_a(win_a), .win_b(win_b), .err_count(err_count), .err_pulse(err_pulse));

   always @(negedge clk) if (rst_n && err_pulse) pulses++;

   task automatic chk(input string req, input int act, input int expv);
      vectors++;
      if (act != expv) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic add_err(input int n);
      exp_events += n;
      exp_cnt = (exp_cnt + n > MAXC) ? MAXC : exp_cnt + n;
   endtask

   // Return both clocks to rest: counter low, check high.
   task automatic park();
      cnt_clk_in = 1'b0;
      tick(1);
      chk_clk_in = 1'b1;
      tick(4);
   endtask

   // Rule A trial: counter rise, check fall j cycles later.
   task automatic trial_a(input string req, input int w, input int j, input bit bad);
      win_a = WW'(w);
      win_b = '0;
      @(negedge clk);
      cnt_clk_in = 1'b1;
      tick(j);
      chk_clk_in = 1'b0;
      tick(w + 6);
      if (bad) add_err(1);
      chk(req, int'(err_count), exp_cnt);
      chk({req, " pulses"}, pulses, exp_events);
      park();
   endtask

   // Rule B trial: check fall, counter rise j cycles later.
   task automatic trial_b(input string req, input int w, input int j, input bit bad);
      win_b = WW'(w);
      win_a = '0;
      @(negedge clk);
      chk_clk_in = 1'b0;
      tick(j);
      cnt_clk_in = 1'b1;
      tick(w + 6);
      if (bad) add_err(1);
      chk(req, int'(err_count), exp_cnt);
      chk({req, " pulses"}, pulses, exp_events);
      park();
   endtask

   initial begin
      tick(3);
      chk("R1 count in reset", int'(err_count), 0);
      chk("R1 pulse in reset", int'(err_pulse), 0);
      rst_n = 1'b1;
      tick(2);
      chk("R1 count after reset", int'(err_count), 0);
      en = 1'b1;
      chk_clk_in = 1'b1;
      tick(6);

      // R5: retrigger inside window, answer late vs first edge, in time vs second.
      win_a = 3'd3; win_b = '0;
      @(negedge clk); cnt_clk_in = 1'b1;
      tick(1); cnt_clk_in = 1'b0;
      tick(1); cnt_clk_in = 1'b1;
      tick(2); chk_clk_in = 1'b0;
      tick(10);
      chk("R5 restart then answered", int'(err_count), exp_cnt);
      park();
      // R5: retrigger, never answered: exactly one error.
      @(negedge clk); cnt_clk_in = 1'b1;
      tick(1); cnt_clk_in = 1'b0;
      tick(1); cnt_clk_in = 1'b1;
      tick(12);
      add_err(1);
      chk("R5 single error after restart", int'(err_count), exp_cnt);
      chk("R9 pulses after restart", pulses, exp_events);
      park();

      // R7: disabled, late answer does nothing.
      en = 1'b0;
      trial_a("R7 disabled rule A", 2, 5, 1'b0);
      trial_b("R7 disabled rule B", 2, 5, 1'b0);
      en = 1'b1;
      tick(4);

      // R6: check clock parked high long enough to go idle.
      tick(IDLE + 8);
      win_a = 3'd2; win_b = '0;
      for (int k = 0; k < 3; k++) begin
         cnt_clk_in = 1'b1; tick(3);
         cnt_clk_in = 1'b0; tick(3);
      end
      tick(6);
      chk("R6 idle check clock", int'(err_count), exp_cnt);
      chk("R6 idle no pulses", pulses, exp_events);
      chk_clk_in = 1'b0; tick(3);
      park();

      // R4: zero length disables each rule.
      trial_a("R4 rule A length 0", 0, 6, 1'b0);
      trial_b("R4 rule B length 0", 0, 6, 1'b0);

      // R2/R3 sweeps; errors when j > w. Saturation (R8) is reached here.
      for (int w = 1; w <= 5; w++)
         for (int j = 0; j <= w + 2; j++)
            trial_a("R2 rule A sweep", w, j, j > w);
      for (int w = 1; w <= 5; w++)
         for (int j = 0; j <= w + 2; j++)
            trial_b("R3 rule B sweep", w, j, j > w);

      chk("R8 saturated count", int'(err_count), MAXC);
      trial_a("R8 hold at max", 1, 3, 1'b1);
      chk("R9 pulses beyond saturation", pulses, exp_events);

      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1'b1;
         vectors++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule